// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM that needs no idle cycles between reads and writes. Commands are sampled on each rising clock edge. A load command starts a burst at the address on the `addr` port. Each later continue command moves that burst one word on, without any address being supplied. Every command is paired with a data-bus slot that falls two enabled cycles after it. A read drives the stored word there. A write samples the incoming word there. Because both kinds of command use the same slot timing, a read can follow a write, or a write follow a read, in the very next cycle.

Each word is made of byte lanes, and every lane carries one parity bit. Writes are masked per lane. When a write command has no lane selected, nothing is stored. The bus output enable is gated by an asynchronous output-enable input, which takes effect within the cycle. Two inputs take priority over all the others. The clock-enable input freezes the whole block for one edge. The sleep input turns the bus off at once and empties the command pipeline.

Top module: `sram_sync_burst`

## Requirements
- R1: After reset, and while reset is held, `dq_oe` is low even with `oe_n` low. The pipeline holds no command and no burst is active.
- R2: A read load (`ce_n`=0, `adv_ld`=0, `we_n`=1) is sampled at enabled edge k. Between enabled edges k+1 and k+2, the stored word at `addr` is driven on `rd_data` and `rd_par` with `dq_oe` high, provided `oe_n` is low and `sleep` is low.
- R3: A write load (`ce_n`=0, `adv_ld`=0, `we_n`=0) is sampled at enabled edge k. At enabled edge k+2 the block stores, for each lane i with `bw_n[i]`=0, the bits `wr_data[8i+7:8i]` and `wr_par[i]`. Lanes that are not selected keep their contents.
- R4: A continue command (`adv_ld`=1) during an active burst repeats the burst's type at the next address. The two low address bits step linearly modulo 4 from the loaded address, and the upper bits stay fixed. `ce_n`, `we_n` and `addr` are ignored. A write continue takes its lane selects from `bw_n` of that cycle.
- R5: A write load or write continue with `bw_n` all ones stores nothing, but a continue still advances the burst address.
- R6: `ce_n`=1 with `adv_ld`=0 ends any burst. A continue while no burst is active stays deselected, stores nothing and drives nothing.
- R7: With `clk_en_n`=1 the edge is ignored. The burst address, the pipeline and the memory hold, and the bus outputs do not change.
- R8: `sleep`=1 forces `dq_oe` low at once, whatever the other inputs are, including `clk_en_n`. It discards the active burst and every pending command, including pending writes. Stored data is kept.
- R9: `oe_n` acts combinationally on `dq_oe` within a cycle. A read whose slot sees `oe_n`=1 drives nothing, but the burst still advances.
- R10: During the data slot of a write command, `dq_oe` is low even with `oe_n` low.
- R11: A read of an address, issued directly after a write to that address, returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, returns to the deselected state |
| clk_en_n | input | 1 | Active-low clock enable; high ignores the edge |
| sleep | input | 1 | Sleep; overrides all other inputs, bus off |
| ce_n | input | 1 | Active-low chip enable, used on load cycles |
| adv_ld | input | 1 | 0 = load a new address, 1 = continue the burst |
| we_n | input | 1 | Active-low write enable, used on load cycles |
| bw_n | input | BYTES | Active-low byte-lane write selects |
| oe_n | input | 1 | Active-low asynchronous output enable |
| addr | input | ADDR_W | Word address for load cycles |
| wr_data | input | BYTES*BYTE_W | Write data, sampled in the write slot |
| wr_par | input | BYTES | Write parity, one bit per lane |
| rd_data | output | BYTES*BYTE_W | Read data, zero when not driven |
| rd_par | output | BYTES | Read parity, one bit per lane |
| dq_oe | output | 1 | Data-bus drive enable (high = driven) |

## Verification
The memory is filled by full-lane write bursts. It is then read back by bursts that start at every one of the four offsets in a group, so that linear wrap order is told apart from simple incrementing. Single writes sweep all four lane masks, and continue bursts alternate live and aborted write cycles, which separates masking from address stepping. Back-to-back write and read pairs check that both commands use the same slot timing. Stalls, sleep during reads and during pending writes, dummy reads, and continues issued while deselected are mixed into bursts, and a reference model follows the slot contents cycle by cycle to check them.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

    // Command carried down the pipeline towards its data slot
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

endpackage

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl
    import sram_burst_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int BYTES      = 2,
    parameter int BURST_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_i,
    input  logic              sleep_i,
    input  logic              ce_n_i,
    input  logic              adv_ld_i,
    input  logic              we_n_i,
    input  logic [BYTES-1:0]  bw_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    output op_e               op_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BYTES-1:0]  mask_o
);

    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << BURST_BITS) - 1);

    typedef struct packed {
        logic                  active;
        logic                  wr;
        logic [ADDR_W-1:0]     base;
        logic [BURST_BITS-1:0] cnt;
    } burst_t;

    burst_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        op_o   = OP_IDLE;
        addr_o = addr_i;
        mask_o = '0;
        if (!adv_ld_i) begin
            if (ce_n_i) begin
                st_d.active = 1'b0;
            end else begin
                st_d.active = 1'b1;
                st_d.wr     = ~we_n_i;
                st_d.base   = addr_i;
                st_d.cnt    = '0;
                op_o        = we_n_i ? OP_READ : OP_WRITE;
                mask_o      = we_n_i ? '0 : ~bw_n_i;
            end
        end else if (st_q.active) begin
            st_d.cnt = st_q.cnt + BURST_BITS'(1);
            op_o     = st_q.wr ? OP_WRITE : OP_READ;
            addr_o   = (st_q.base & ~LOW_MASK)
                     | ((st_q.base + ADDR_W'(st_d.cnt)) & LOW_MASK);
            mask_o   = st_q.wr ? ~bw_n_i : '0;
        end
        if (sleep_i) begin
            st_d   = '0;
            op_o   = OP_IDLE;
            mask_o = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (!hold_i || sleep_i) begin
            st_q <= st_d;
        end
    end

    // R4
    cont_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && !sleep_i && adv_ld_i && st_q.active)
        |=> (st_q.cnt == $past(st_q.cnt) + BURST_BITS'(1)));

    // R6
    desel_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && !sleep_i && ce_n_i && !adv_ld_i) |=> !st_q.active);

    // R7
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !sleep_i) |=> $stable(st_q));

endmodule

// File: rtl/sram_cmd_pipe.sv
module sram_cmd_pipe
    import sram_burst_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_i,
    input  logic              sleep_i,
    input  op_e               op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTES-1:0]  mask_i,
    output op_e               slot_op_o,
    output logic [ADDR_W-1:0] slot_addr_o,
    output logic [BYTES-1:0]  slot_mask_o,
    output logic              commit_o
);

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [BYTES-1:0]  mask;
    } stage_t;

    typedef struct packed {
        stage_t s1;
        stage_t s2;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d = pipe_q;
        if (sleep_i) begin
            pipe_d = '0;
        end else if (!hold_i) begin
            pipe_d.s1.op   = op_i;
            pipe_d.s1.addr = addr_i;
            pipe_d.s1.mask = mask_i;
            pipe_d.s2      = pipe_q.s1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign slot_op_o   = pipe_q.s2.op;
    assign slot_addr_o = pipe_q.s2.addr;
    assign slot_mask_o = pipe_q.s2.mask;
    assign commit_o    = !hold_i && !sleep_i && (pipe_q.s2.op == OP_WRITE);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !sleep_i) |=> $stable(pipe_q));

    // R8
    sleep_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> (pipe_q.s1.op == OP_IDLE && pipe_q.s2.op == OP_IDLE));

endmodule

// File: rtl/sram_store.sv
module sram_store #(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    wr_en_i,
    input  logic [ADDR_W-1:0]       wr_addr_i,
    input  logic [BYTES-1:0]        wr_be_i,
    input  logic [BYTES*BYTE_W-1:0] wr_data_i,
    input  logic [BYTES-1:0]        wr_par_i,
    input  logic [ADDR_W-1:0]       rd_addr_i,
    output logic [BYTES*BYTE_W-1:0] rd_data_o,
    output logic [BYTES-1:0]        rd_par_o
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LANE_W = BYTE_W + 1;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        logic [LANE_W-1:0] lane_q [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en_i && wr_be_i[b]) begin
                lane_q[wr_addr_i] <= {wr_par_i[b], wr_data_i[b*BYTE_W +: BYTE_W]};
            end
        end

        assign rd_data_o[b*BYTE_W +: BYTE_W] = lane_q[rd_addr_i][BYTE_W-1:0];
        assign rd_par_o[b]                   = lane_q[rd_addr_i][BYTE_W];
    end

endmodule

// File: rtl/sram_sync_burst.sv
module sram_sync_burst
    import sram_burst_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int BYTES      = 2,
    parameter int BYTE_W     = 8,
    parameter int BURST_BITS = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic                    sleep,
    input  logic                    ce_n,
    input  logic                    adv_ld,
    input  logic                    we_n,
    input  logic [BYTES-1:0]        bw_n,
    input  logic                    oe_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BYTES*BYTE_W-1:0] wr_data,
    input  logic [BYTES-1:0]        wr_par,
    output logic [BYTES*BYTE_W-1:0] rd_data,
    output logic [BYTES-1:0]        rd_par,
    output logic                    dq_oe
);

    op_e                     cmd_op;
    logic [ADDR_W-1:0]       cmd_addr;
    logic [BYTES-1:0]        cmd_mask;
    op_e                     slot_op;
    logic [ADDR_W-1:0]       slot_addr;
    logic [BYTES-1:0]        slot_mask;
    logic                    commit;
    logic [BYTES*BYTE_W-1:0] arr_data;
    logic [BYTES-1:0]        arr_par;

    sram_burst_ctrl #(
        .ADDR_W     (ADDR_W),
        .BYTES      (BYTES),
        .BURST_BITS (BURST_BITS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_i   (clk_en_n),
        .sleep_i  (sleep),
        .ce_n_i   (ce_n),
        .adv_ld_i (adv_ld),
        .we_n_i   (we_n),
        .bw_n_i   (bw_n),
        .addr_i   (addr),
        .op_o     (cmd_op),
        .addr_o   (cmd_addr),
        .mask_o   (cmd_mask)
    );

    sram_cmd_pipe #(
        .ADDR_W (ADDR_W),
        .BYTES  (BYTES)
    ) u_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_i      (clk_en_n),
        .sleep_i     (sleep),
        .op_i        (cmd_op),
        .addr_i      (cmd_addr),
        .mask_i      (cmd_mask),
        .slot_op_o   (slot_op),
        .slot_addr_o (slot_addr),
        .slot_mask_o (slot_mask),
        .commit_o    (commit)
    );

    sram_store #(
        .ADDR_W (ADDR_W),
        .BYTES  (BYTES),
        .BYTE_W (BYTE_W)
    ) u_store (
        .clk       (clk),
        .wr_en_i   (commit),
        .wr_addr_i (slot_addr),
        .wr_be_i   (slot_mask),
        .wr_data_i (wr_data),
        .wr_par_i  (wr_par),
        .rd_addr_i (slot_addr),
        .rd_data_o (arr_data),
        .rd_par_o  (arr_par)
    );

    // Bus drive: read slot, output enable active, not asleep
    always_comb begin
        dq_oe   = (slot_op == OP_READ) && !oe_n && !sleep;
        rd_data = dq_oe ? arr_data : '0;
        rd_par  = dq_oe ? arr_par : '0;
    end

    // R2
    read_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !sleep && !adv_ld && !ce_n && we_n) ##1 (!clk_en_n && !sleep)
        |=> (slot_op == OP_READ && slot_addr == $past(addr, 2)));

    // R10
    write_slot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !sleep && !adv_ld && !ce_n && !we_n) ##1 (!clk_en_n && !sleep)
        |=> !dq_oe);

endmodule

// File: tb/test_sram_sync_burst.sv
module test_sram_sync_burst;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        clk_en_n;
    logic        sleep;
    logic        ce_n;
    logic        adv_ld;
    logic        we_n;
    logic [1:0]  bw_n;
    logic        oe_n;
    logic [5:0]  addr;
    logic [15:0] wr_data;
    logic [1:0]  wr_par;
    logic [15:0] rd_data;
    logic [1:0]  rd_par;
    logic        dq_oe;

    sram_sync_burst #(
        .ADDR_W (6),
        .BYTES (2),
        .BYTE_W (8),
        .BURST_BITS (2)
    ) i_sram_sync_burst (
        .clk (clk), .rst_n (rst_n), .clk_en_n (clk_en_n), .sleep (sleep),
        .ce_n (ce_n), .adv_ld (adv_ld), .we_n (we_n), .bw_n (bw_n),
        .oe_n (oe_n), .addr (addr), .wr_data (wr_data), .wr_par (wr_par),
        .rd_data (rd_data), .rd_par (rd_par), .dq_oe (dq_oe)
    );

    always #(CLK_P/2) clk = ~clk;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string g_req = "R1";
    logic  g_oe_n = 1'b0;
    int    g_salt = 0;

    // reference: shadow memory, two pending slots, burst state
    logic [15:0] smem [64];
    logic [1:0]  spar [64];
    int          m_op   [2];
    int          m_addr [2];
    logic [1:0]  m_mask [2];
    bit          b_act = 0;
    bit          b_wr  = 0;
    int          b_base = 0;
    int          b_cnt  = 0;

    function automatic logic [15:0] wpat(input int a, input int s);
        return 16'((a * 1237) ^ (s * 40503) ^ (a << 10));
    endfunction

    function automatic logic [1:0] ppat(input int a, input int s);
        return 2'(a + s * 3);
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic s_ce, input logic s_adv, input logic s_we,
                        input logic [1:0] s_bw, input int s_addr,
                        input logic s_cen, input logic s_slp);
        logic        exp_oe;
        logic [15:0] wd;
        logic [1:0]  wp;
        int          nop;
        int          na;
        logic [1:0]  nm;
        @(negedge clk);
        sleep = s_slp;
        oe_n  = g_oe_n;
        #1;
        exp_oe = !s_slp && (m_op[1] == 1) && !g_oe_n;
        n_chk++;
        if (dq_oe !== exp_oe ||
            (exp_oe && (rd_data !== smem[m_addr[1]] || rd_par !== spar[m_addr[1]]))) begin
            n_bad++;
            $display("FAIL %s: oe=%b data=%h par=%h expected oe=%b data=%h par=%h (addr %0d)",
                     g_req, dq_oe, rd_data, rd_par, exp_oe,
                     smem[m_addr[1]], spar[m_addr[1]], m_addr[1]);
        end
        wd = wpat(m_addr[1], g_salt);
        wp = ppat(m_addr[1], g_salt);
        if (s_cen) begin
            wd = ~wd;
            wp = ~wp;
        end
        ce_n = s_ce; adv_ld = s_adv; we_n = s_we; bw_n = s_bw;
        addr = 6'(s_addr); clk_en_n = s_cen; wr_data = wd; wr_par = wp;
        if (s_slp) begin
            m_op[0] = 0; m_op[1] = 0; b_act = 0;
        end else if (!s_cen) begin
            if (m_op[1] == 2) begin
                for (int i = 0; i < 2; i++) begin
                    if (m_mask[1][i]) begin
                        smem[m_addr[1]][8*i +: 8] = wd[8*i +: 8];
                        spar[m_addr[1]][i] = wp[i];
                    end
                end
            end
            nop = 0; na = 0; nm = 2'b00;
            if (!s_adv) begin
                if (s_ce) begin
                    b_act = 0;
                end else begin
                    b_act = 1; b_wr = !s_we; b_base = s_addr; b_cnt = 0;
                    nop = s_we ? 1 : 2; na = s_addr; nm = s_we ? 2'b00 : ~s_bw;
                end
            end else if (b_act) begin
                b_cnt = (b_cnt + 1) % 4;
                nop = b_wr ? 2 : 1;
                na = (b_base & ~3) | ((b_base + b_cnt) & 3);
                nm = b_wr ? ~s_bw : 2'b00;
            end
            m_op[1] = m_op[0]; m_addr[1] = m_addr[0]; m_mask[1] = m_mask[0];
            m_op[0] = nop;     m_addr[0] = na;        m_mask[0] = nm;
        end
    endtask

    task automatic rd(input int a);                 step(0, 0, 1, 2'b11, a, 0, 0);  endtask
    task automatic wr(input int a, input logic [1:0] bw); step(0, 0, 0, bw, a, 0, 0); endtask
    task automatic cn(input logic [1:0] bw);        step(1, 1, 1, bw, 0, 0, 0);     endtask
    task automatic ds();                            step(1, 0, 1, 2'b11, 0, 0, 0);  endtask
    task automatic stl();                           step(0, 0, 0, 2'b00, 63, 1, 0); endtask
    task automatic slp();                           step(0, 0, 0, 2'b00, 63, 0, 1); endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        m_op[0] = 0; m_op[1] = 0; m_addr[0] = 0; m_addr[1] = 0;
        m_mask[0] = 2'b00; m_mask[1] = 2'b00;
        rst_n = 1'b0; clk_en_n = 1'b0; sleep = 1'b0; ce_n = 1'b1; adv_ld = 1'b0;
        we_n = 1'b1; bw_n = 2'b11; oe_n = 1'b0; addr = '0; wr_data = '0; wr_par = '0;

        // R1: bus off during and after reset, with oe_n low
        repeat (3) @(negedge clk);
        #1 chk(dq_oe === 1'b0, "R1 in reset", 32'(dq_oe), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        g_req = "R1";
        repeat (3) ds();

        // R3 R4 R10: fill memory with full-lane write bursts
        g_req = "R3 R4 R10 fill";
        g_salt = 1;
        for (int g = 0; g < 16; g++) begin
            wr(4 * g, 2'b00);
            repeat (3) cn(2'b00);
        end
        ds(); ds();

        // R2 R4: read back, bursts starting at every offset (wrap order)
        g_req = "R2 R4 wrap read";
        for (int g = 0; g < 16; g++) begin
            rd(4 * g + (g % 4));
            repeat (3) cn(2'b11);
        end
        ds(); ds();

        // R3 R5: every lane mask on single writes
        g_req = "R3 R5 lane mask";
        g_salt = 2;
        for (int m = 0; m < 4; m++) begin
            wr(40 + m, ~2'(m));
            ds();
        end
        ds(); ds();
        rd(40); repeat (3) cn(2'b11); ds(); ds();

        // R5: aborted continue cycles still advance the address
        g_req = "R5 abort";
        g_salt = 3;
        wr(8, 2'b00); cn(2'b11); cn(2'b00); cn(2'b11); ds(); ds();
        rd(8); repeat (3) cn(2'b11); ds(); ds();

        // R11: read right after write, write right after read
        g_req = "R11 turnaround";
        g_salt = 4;
        wr(20, 2'b00); rd(20); rd(21); wr(21, 2'b00); rd(21); ds(); ds(); ds();

        // R9: async output enable and dummy read
        g_req = "R9 oe";
        rd(0); cn(2'b11); cn(2'b11);
        oe_n = 1'b1;
        #1 chk(dq_oe === 1'b0, "R9 oe_n high mid-cycle", 32'(dq_oe), 32'd0);
        oe_n = 1'b0;
        #1 chk(dq_oe === 1'b1 && rd_data === smem[0], "R9 oe_n low mid-cycle",
               {15'd0, dq_oe, rd_data}, {15'd0, 1'b1, smem[0]});
        g_oe_n = 1'b1; cn(2'b11);
        g_oe_n = 1'b0; ds(); ds(); ds();

        // R7: stalls inside read and write bursts
        g_req = "R7 stall";
        rd(4); stl(); cn(2'b11); stl(); stl(); cn(2'b11); cn(2'b11); stl(); ds(); ds();
        g_salt = 5;
        wr(50, 2'b00); cn(2'b00); stl(); stl(); cn(2'b00); stl(); ds(); ds();
        rd(50); repeat (3) cn(2'b11); ds(); ds();

        // R8: sleep during read, and sleep dropping pending writes
        g_req = "R8 sleep";
        rd(12); cn(2'b11); slp(); cn(2'b11); ds(); ds();
        g_salt = 6;
        wr(60, 2'b00); cn(2'b00); slp(); ds(); ds();
        rd(60); repeat (3) cn(2'b11); ds(); ds();

        // R6: continue while deselected does nothing
        g_req = "R6 deselect";
        ds(); step(0, 1, 0, 2'b00, 36, 0, 0); cn(2'b11); ds(); ds();
        rd(36); cn(2'b11); ds(); ds();

        finish_run();
    end

endmodule